// File: doc/BRIEF.md
# Cache Invalidation Command Queue Engine

This block drains a ring of invalidation commands that software places in memory. Software fills command slots and then moves the tail pointer forward through a small register port. Whenever the head pointer differs from the tail pointer, the engine fetches the command at the head slot. If the command is an invalidate-by-index command, the engine pulses an invalidate strobe carrying a 16-bit entry index toward the remapping entry cache. If the command also asks for a completion notice, the engine fetches the notice address and writes a nonzero word there. Software spins on that word to learn that the stale entry can no longer be used. Only after this does the head pointer move on by one slot.

The ring holds 4096 slots of 16 bytes each. Slot `n` starts at the 4 KB-aligned ring base plus `16*n`. Word 0 of a slot, at byte offset 0, carries the control fields. Word 1, at byte offset 8, carries the notice address. Commands are handled strictly one at a time, in ring order. The memory port allows one outstanding request and is kept deliberately simple.

The controller is a single state machine with eight states:
- `ST_IDLE` waits for head != tail.
- `ST_FETCH_LO` requests word 0, and moves to `ST_WAIT_LO` on grant.
- `ST_WAIT_LO` takes the read data. It goes to `ST_INVAL` for an invalidate-by-index command and to `ST_RETIRE` for any other type.
- `ST_INVAL` pulses the strobe. It goes to `ST_FETCH_HI` when a notice is requested, else to `ST_RETIRE`.
- `ST_FETCH_HI` requests word 1, and moves to `ST_WAIT_HI` on grant.
- `ST_WAIT_HI` captures the notice address on read data and moves to `ST_NOTIFY`.
- `ST_NOTIFY` issues the notice write, and moves to `ST_RETIRE` on grant.
- `ST_RETIRE` advances head and returns to `ST_IDLE`.

Top module: `inv_cmdq_engine`

## Requirements
- R1: After reset, the head, tail and base registers read 0, `inv_valid` is low and `mem_req` is low.
- R2: Register select 0 is the base register. Bits [47:12] are the ring address and bits [3:0] are a size code; every other bit reads 0. Select 1 is head and select 2 is tail; each keeps only the low 12 bits of the written data and reads back zero-extended.
- R3: While head equals tail, the engine issues no memory request and no invalidate strobe.
- R4: When a tail write makes the ring non-empty while the engine is idle, a read request appears in the cycle after the tail register updates. Its address is base + 16*head. Every request keeps `mem_req`, `mem_addr` and `mem_we` stable until `mem_gnt`. Read data is taken on the `mem_rvalid` that follows a read grant. A write is complete at its grant.
- R5: In word 0, bit 4 is the type (0 = invalidate by index), bit 5 is the notice request and bits [23:8] are the entry index. For type 0, `inv_valid` is high for exactly one cycle, with `inv_index` equal to bits [23:8]. Strobes occur in ring order.
- R6: For a type 0 command with bit 5 set, the engine reads word 1 at slot address + 8. It then writes `NOTIFY_VAL` (nonzero, default 1) to the address in the low 48 bits of word 1. Commands with bit 5 clear cause no memory write.
- R7: A notice write is issued only after the invalidate strobe of the same command.
- R8: A command with bit 4 set produces no strobe, no word 1 read and no write, even with bit 5 set, and head still advances past it.
- R9: Head advances by exactly one per completed command, and the engine stops once head equals tail.
- R10: Head wraps from 4095 to 0, and slot addresses follow the wrap.
- R11: A head write is accepted only while the engine is idle; while it is busy the write is ignored. Tail writes are accepted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 base, 1 head, 2 tail |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_sel | input | 2 | Read select, same encoding as the write target |
| reg_rd_data | output | 64 | Selected register value (combinational) |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address of the 64-bit access |
| mem_wdata | output | 64 | Write data for a notice write |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| inv_valid | output | 1 | One-cycle invalidate strobe |
| inv_index | output | 16 | Entry index to invalidate |

## Verification
The hardest behaviour to provoke is a software head write that lands while a command is in flight. The engine only becomes busy through its own response to a tail write, and its busy window depends on memory latency. The bench therefore loads several commands, writes tail, and waits until it sees `mem_req` high before it writes a far-off head value. It then confirms that the queue drains to the tail value rather than to the written one. The wrap-around case is reached by writing head near the top of the ring while the engine is idle, so that the few loaded commands straddle slot 4095. Memory grants and read latencies are randomised with a fixed seed, which exercises request holding and the ordering of notice writes after strobes.

// File: rtl/inv_cmdq_pkg.sv
`timescale 1ns/1ps
package inv_cmdq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_WAIT_LO,
        ST_INVAL,
        ST_FETCH_HI,
        ST_WAIT_HI,
        ST_NOTIFY,
        ST_RETIRE
    } eng_state_e;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    localparam int  CMD_TYPE_BIT   = 4;
    localparam int  CMD_NOTIFY_BIT = 5;
    localparam int  CMD_IDX_LSB    = 8;
    localparam logic CMD_TYPE_BY_INDEX = 1'b0;

endpackage

// File: rtl/inv_cmdq_regs.sv
`timescale 1ns/1ps
module inv_cmdq_regs
    import inv_cmdq_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int ADDR_W = 48,
    parameter int REG_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    input  logic              busy,
    input  logic              head_adv,
    output logic [REG_W-1:0]  rd_data,
    output logic [IDX_W-1:0]  head_idx,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [ADDR_W-1:0] ring_base
);
    localparam int PAGE_SHIFT = 12;
    localparam int SIZE_W     = 4;

    logic [ADDR_W-1:PAGE_SHIFT] base_hi_q;
    logic [SIZE_W-1:0]          size_q;
    logic [IDX_W-1:0]           head_q;
    logic [IDX_W-1:0]           tail_q;
    logic                       unused_wr_bits;

    assign unused_wr_bits = ^wr_data[REG_W-1:ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi_q <= '0;
            size_q    <= '0;
            head_q    <= '0;
            tail_q    <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_BASE) begin
                base_hi_q <= wr_data[ADDR_W-1:PAGE_SHIFT];
                size_q    <= wr_data[SIZE_W-1:0];
            end
            if (wr_en && wr_sel == SEL_TAIL)
                tail_q <= wr_data[IDX_W-1:0];
            if (wr_en && wr_sel == SEL_HEAD && !busy)
                head_q <= wr_data[IDX_W-1:0];
            else if (head_adv)
                head_q <= head_q + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_BASE: begin
                rd_data[ADDR_W-1:PAGE_SHIFT] = base_hi_q;
                rd_data[SIZE_W-1:0]          = size_q;
            end
            SEL_HEAD: rd_data[IDX_W-1:0] = head_q;
            SEL_TAIL: rd_data[IDX_W-1:0] = tail_q;
            default:  rd_data = '0;
        endcase
    end

    assign head_idx  = head_q;
    assign tail_idx  = tail_q;
    assign ring_base = {base_hi_q, {PAGE_SHIFT{1'b0}}};

endmodule

// File: rtl/inv_cmdq_fsm.sv
`timescale 1ns/1ps
module inv_cmdq_fsm
    import inv_cmdq_pkg::*;
#(
    parameter int              IDX_W      = 12,
    parameter int              ADDR_W     = 48,
    parameter int              DATA_W     = 64,
    parameter int              ENT_W      = 16,
    parameter logic [DATA_W-1:0] NOTIFY_VAL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [IDX_W-1:0]  tail_idx,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              inv_valid,
    output logic [ENT_W-1:0]  inv_index,
    output logic              head_adv,
    output logic              busy
);
    localparam int SLOT_SHIFT = 4;
    localparam int WORD_BYTES = DATA_W / 8;

    eng_state_e        state_q, state_d;
    logic [ENT_W-1:0]  idx_q;
    logic              ntf_q;
    logic [ADDR_W-1:0] naddr_q;
    logic [ADDR_W-1:0] slot_addr;
    logic              unused_rd_bits;

    assign unused_rd_bits = ^mem_rdata[DATA_W-1:ADDR_W];
    assign slot_addr = ring_base + ADDR_W'({head_idx, {SLOT_SHIFT{1'b0}}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (head_idx != tail_idx) state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_gnt) state_d = ST_WAIT_LO;
            ST_WAIT_LO:
                if (mem_rvalid)
                    state_d = (mem_rdata[CMD_TYPE_BIT] == CMD_TYPE_BY_INDEX)
                              ? ST_INVAL : ST_RETIRE;
            ST_INVAL:    state_d = ntf_q ? ST_FETCH_HI : ST_RETIRE;
            ST_FETCH_HI: if (mem_gnt) state_d = ST_WAIT_HI;
            ST_WAIT_HI:  if (mem_rvalid) state_d = ST_NOTIFY;
            ST_NOTIFY:   if (mem_gnt) state_d = ST_RETIRE;
            ST_RETIRE:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            ntf_q   <= 1'b0;
            naddr_q <= '0;
        end else begin
            if (state_q == ST_WAIT_LO && mem_rvalid) begin
                idx_q <= mem_rdata[CMD_IDX_LSB +: ENT_W];
                ntf_q <= mem_rdata[CMD_NOTIFY_BIT];
            end
            if (state_q == ST_WAIT_HI && mem_rvalid)
                naddr_q <= mem_rdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = slot_addr;
        mem_wdata = NOTIFY_VAL;
        inv_valid = 1'b0;
        head_adv  = 1'b0;
        unique case (state_q)
            ST_FETCH_LO: mem_req = 1'b1;
            ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr + ADDR_W'(WORD_BYTES);
            end
            ST_NOTIFY: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = naddr_q;
            end
            ST_INVAL:  inv_valid = 1'b1;
            ST_RETIRE: head_adv  = 1'b1;
            default: ;
        endcase
    end

    assign inv_index = idx_q;
    assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/inv_cmdq_engine.sv
`timescale 1ns/1ps
module inv_cmdq_engine
    import inv_cmdq_pkg::*;
#(
    parameter int                IDX_W      = 12,
    parameter int                ADDR_W     = 48,
    parameter int                DATA_W     = 64,
    parameter int                ENT_W      = 16,
    parameter logic [DATA_W-1:0] NOTIFY_VAL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              inv_valid,
    output logic [ENT_W-1:0]  inv_index
);
    logic [IDX_W-1:0]  head_idx;
    logic [IDX_W-1:0]  tail_idx;
    logic [ADDR_W-1:0] ring_base;
    logic              head_adv;
    logic              busy;

    inv_cmdq_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REG_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .busy      (busy),
        .head_adv  (head_adv),
        .rd_data   (reg_rd_data),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .ring_base (ring_base)
    );

    inv_cmdq_fsm #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ENT_W(ENT_W), .NOTIFY_VAL(NOTIFY_VAL)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .ring_base  (ring_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .inv_valid  (inv_valid),
        .inv_index  (inv_index),
        .head_adv   (head_adv),
        .busy       (busy)
    );

endmodule

// File: rtl/inv_cmdq_chk.sv
`timescale 1ns/1ps
module inv_cmdq_chk
    import inv_cmdq_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              inv_valid,
    input logic [IDX_W-1:0]  head_idx,
    input logic [IDX_W-1:0]  tail_idx,
    input logic              busy
);
    logic             sw_head_wr;
    logic [IDX_W-1:0] head_prev_q;
    logic             inv_seen_q;

    assign sw_head_wr = reg_wr_en && reg_wr_sel == SEL_HEAD && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_prev_q <= '0;
            inv_seen_q  <= 1'b0;
        end else begin
            head_prev_q <= head_idx;
            if (head_idx != head_prev_q) inv_seen_q <= 1'b0;
            else if (inv_valid)          inv_seen_q <= 1'b1;
        end
    end

    // R3
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && head_idx == tail_idx) |-> (!mem_req && !inv_valid));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    inv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);

    // R7
    notify_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> inv_seen_q);

    // R9
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((head_idx != $past(head_idx)) && !$past(sw_head_wr))
        |-> (head_idx == IDX_W'($past(head_idx) + 1'b1)));

    // R11
    head_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_wr_sel == SEL_HEAD)
        |=> (head_idx == $past(head_idx) || head_idx == IDX_W'($past(head_idx) + 1'b1)));

endmodule

bind inv_cmdq_engine inv_cmdq_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_sel (reg_wr_sel),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .inv_valid  (inv_valid),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .busy       (busy)
);

// File: tb/inv_cmdq_engine_tb_top.sv
`timescale 1ns/1ps
module inv_cmdq_engine_tb_top;

    localparam logic [47:0] BASE      = 48'h0000_1234_5000;
    localparam logic [47:0] NOTE_BASE = 48'h0080_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [63:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [63:0] reg_rd_data;
    logic        mem_req, mem_we;
    logic [47:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        inv_valid;
    logic [15:0] inv_index;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int note_ctr = 0;

    logic [63:0] mem_model [logic [47:0]];
    logic [15:0] notify_map [logic [47:0]];
    logic [15:0] exp_inv [$];
    logic [15:0] got_inv [$];
    logic [47:0] want_set [$];
    logic [47:0] want_zero [$];

    inv_cmdq_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .inv_valid(inv_valid), .inv_index(inv_index)
    );

    initial forever #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [63:0] make_lo(input bit typ, input bit ntf, input logic [15:0] idx);
        logic [63:0] w = '0;
        w[4] = typ;
        w[5] = ntf;
        w[23:8] = idx;
        return w;
    endfunction

    function automatic logic [47:0] slot_addr(input int slot);
        return BASE + 48'((slot % 4096) * 16);
    endfunction

    // Strobe monitor and memory model share one loop so their order is fixed.
    initial begin
        int rd_wait = 0;
        logic [47:0] rd_addr = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (inv_valid === 1'b1) got_inv.push_back(inv_index);
            if (rd_wait > 0) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_model.exists(rd_addr) ? mem_model[rd_addr] : 64'h0;
                end
            end else if (mem_req === 1'b1 && $urandom_range(0, 2) != 0) begin
                mem_gnt = 1'b1;
                if (mem_we) begin
                    if (!notify_map.exists(mem_addr)) begin
                        check(1'b0, "R6 unexpected write", {16'h0, mem_addr}, 64'h0);
                    end else begin
                        // R7: strobe for this command already seen
                        check(got_inv.size() > 0 && got_inv[got_inv.size()-1] == notify_map[mem_addr],
                              "R7 notice before strobe",
                              (got_inv.size() > 0) ? 64'(got_inv[got_inv.size()-1]) : 64'hFFFF_FFFF,
                              64'(notify_map[mem_addr]));
                        check(mem_wdata != 64'h0, "R6 nonzero notice", mem_wdata, 64'h1);
                    end
                    mem_model[mem_addr] = mem_wdata;
                end else begin
                    rd_addr = mem_addr;
                    rd_wait = $urandom_range(1, 3);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_sel = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [63:0] val);
        reg_rd_sel = sel;
        #1;
        val = reg_rd_data;
    endtask

    task automatic put_cmd(input int slot, input bit typ, input bit ntf, input logic [15:0] idx);
        logic [47:0] a = slot_addr(slot);
        logic [47:0] na = NOTE_BASE + 48'(note_ctr * 64);
        note_ctr++;
        mem_model[a] = make_lo(typ, ntf, idx);
        mem_model[a + 48'd8] = {16'hDEAD, na};
        mem_model[na] = 64'h0;
        if (!typ) exp_inv.push_back(idx);
        if (!typ && ntf) begin
            notify_map[na] = idx;
            want_set.push_back(na);
        end else begin
            want_zero.push_back(na);
        end
    endtask

    task automatic load_random(input int start, input int n);
        for (int k = 0; k < n; k++)
            put_cmd(start + k, ($urandom_range(0, 4) == 0), $urandom_range(0, 1) == 1,
                    16'($urandom));
    endtask

    task automatic wait_idle();
        logic [63:0] h, t;
        int n = 0;
        forever begin
            @(negedge clk);
            reg_read(2'd1, h);
            reg_read(2'd2, t);
            if (h == t && mem_req === 1'b0) break;
            n++;
            if (n > 20000) begin
                check(1'b0, "R9 drain timeout", h, t);
                break;
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_batch(input logic [11:0] exp_head, input string tag);
        logic [63:0] h;
        // R5: strobes in ring order with the right index
        check(got_inv.size() == exp_inv.size(), {"R5 strobe count ", tag},
              64'(got_inv.size()), 64'(exp_inv.size()));
        for (int k = 0; k < exp_inv.size() && k < got_inv.size(); k++)
            check(got_inv[k] == exp_inv[k], {"R5 strobe index ", tag},
                  64'(got_inv[k]), 64'(exp_inv[k]));
        foreach (want_set[k])
            check(mem_model[want_set[k]] == 64'h1, {"R6 notice word ", tag},
                  mem_model[want_set[k]], 64'h1);
        foreach (want_zero[k])
            check(mem_model[want_zero[k]] == 64'h0, {"R8 no notice ", tag},
                  mem_model[want_zero[k]], 64'h0);
        reg_read(2'd1, h);
        check(h == 64'(exp_head), {"R9 final head ", tag}, h, 64'(exp_head));
        exp_inv.delete();
        got_inv.delete();
        want_set.delete();
        want_zero.delete();
    endtask

    initial begin
        logic [63:0] v;
        bit quiet;
        void'($urandom(32'd777));

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, v); check(v == 64'h0, "R1 base", v, 64'h0);
        reg_read(2'd1, v); check(v == 64'h0, "R1 head", v, 64'h0);
        reg_read(2'd2, v); check(v == 64'h0, "R1 tail", v, 64'h0);
        check(inv_valid == 1'b0, "R1 inv_valid", 64'(inv_valid), 64'h0);
        check(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'h0);

        // R2 base field masking
        reg_write(2'd0, 64'hABCD_0012_3456_7FFF);
        reg_read(2'd0, v); check(v == 64'h0000_0012_3456_700F, "R2 base fields", v, 64'h0000_0012_3456_700F);
        reg_write(2'd0, {16'h0, BASE} | 64'h3);
        reg_read(2'd0, v); check(v == ({16'h0, BASE} | 64'h3), "R2 base value", v, {16'h0, BASE} | 64'h3);

        // R3 empty ring: tail write equal to head starts nothing
        reg_write(2'd2, 64'h0);
        quiet = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_req !== 1'b0 || inv_valid !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R3 empty stays quiet", 64'(quiet), 64'h1);

        // R10 wrap: idle head write to 4090 drains slots 4090..4095 back to 0
        for (int k = 0; k < 6; k++)
            put_cmd(4090 + k, 1'b0, (k % 2) == 0, 16'hA000 + 16'(k));
        reg_write(2'd1, 64'h0000_0001_0000_0FFA);
        wait_idle();
        check_batch(12'd0, "R10 wrap");

        // R4 start timing and slot address, R2 tail masking
        put_cmd(0, 1'b0, 1'b1, 16'h1111);
        put_cmd(1, 1'b1, 1'b1, 16'h2222);
        put_cmd(2, 1'b0, 1'b0, 16'h3333);
        put_cmd(3, 1'b0, 1'b1, 16'h4444);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_sel = 2'd2;
        reg_wr_data = 64'hABCD_0000_0000_1004;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(mem_req == 1'b0, "R4 no request before tail update settles", 64'(mem_req), 64'h0);
        reg_read(2'd2, v); check(v == 64'h4, "R2 tail masked", v, 64'h4);
        @(negedge clk);
        check(mem_req == 1'b1 && mem_we == 1'b0, "R4 request next cycle", 64'(mem_req), 64'h1);
        check(mem_addr == slot_addr(0), "R4 slot address", {16'h0, mem_addr}, {16'h0, slot_addr(0)});
        wait_idle();
        check_batch(12'd4, "R4/R8 directed");

        // R5..R9 random batch
        load_random(4, 24);
        reg_write(2'd2, 64'd28);
        wait_idle();
        check_batch(12'd28, "random");

        // R11 head write while busy is ignored
        load_random(28, 4);
        reg_write(2'd2, 64'd32);
        while (mem_req !== 1'b1) @(negedge clk);
        reg_write(2'd1, 64'd100);
        wait_idle();
        reg_read(2'd2, v);
        check(v == 64'd32, "R11 tail kept", v, 64'd32);
        check_batch(12'd32, "R11 busy head write");

        done = 1;
        finish_run();
    end

endmodule